// File: doc/BRIEF.md
# One-Time-Programmable Memory Command Engine with CRC-16

This block carries out the memory-level commands of a small one-time-programmable (OTP) store once the device has already been selected on its serial bus. The store has two fields. The data field is 192 bytes at addresses 0000h to 00BFh, arranged as six pages of 32 bytes. The status field is 8 bytes at 0100h to 0107h. Every bit starts at 1 and can only ever be cleared. Host bytes arrive on a byte-wide receive strobe. Bytes the host reads back are produced one per request on a transmit port. A separate input strobe stands in for the external programming pulse.

A sequence opens with a command byte and a two-byte address, low byte first. Reads stream stored bytes up to the end of their field, then a 16-bit CRC, then all-ones filler. Writes work through the same auto-incrementing address: the host supplies a data byte, reads back a CRC-16, fires the programming strobe, and reads the stored byte back to verify it. The engine never checks the host's CRC. A bus-level reset ends any sequence and leaves the stored contents alone. The chip reset returns both fields to the erased state.

Top module: `otp_cmd_engine`

## Requirements
- R1: A sequence starts only with one of four command bytes: F0h (read data field), 0Fh (write data field), AAh (read status field) or 55h (write status field). The next two received bytes are the address, low byte then high byte. Any other byte received while waiting for a command is dropped, and the engine keeps waiting for a command.
- R2: After chip reset, tx_valid is 0, tx_byte is FFh, and every byte of both fields reads as FFh.
- R3: A programming strobe ANDs the held data byte into the addressed byte. A stored bit can only go from 1 to 0.
- R4: In a write, the two bytes returned after the data byte are a CRC-16 with polynomial x^16+x^15+x^2+1. Bits are shifted in least significant first and the CRC starts from zero. It covers the command byte, address low, address high and the data byte, and is returned low byte first.
- R5: After the strobe, the next read returns the stored byte at the current address. The address then steps by one.
- R6: Each further data byte in the same write sequence gets a CRC whose register was loaded (not shifted) with {00h, new address low byte}, and then had the data byte shifted in.
- R7: Read data field (F0h) returns bytes from the start address through 00BFh. It then returns a CRC-16 of those data bytes only, starting from zero and low byte first, and after that FFh for every request.
- R8: Read status field (AAh) first returns the CRC-16 of the command and both address bytes. It then returns the status bytes through 0107h, then a CRC-16 of those bytes starting from zero, then FFh.
- R9: A programming strobe that arrives while the engine is not waiting for one changes no stored byte.
- R10: A write aimed outside the writable range still returns its CRC and verify byte. Data writes are writable only at 0000h–00BFh and status writes only at 0100h–0106h. The strobe leaves memory unchanged there, and the verify byte reads FFh.
- R11: bus_rst returns the engine to waiting for a command and keeps stored contents. A read it cuts short gets no CRC: later requests return FFh.
- R12: A read whose start address lies outside its field returns FFh for every request and no CRC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Chip reset, synchronous, active high; erases both fields |
| bus_rst | input | 1 | Bus-level reset; ends the current sequence, keeps contents |
| rx_valid | input | 1 | Host byte present on rx_byte this cycle |
| rx_byte | input | 8 | Byte from host |
| tx_req | input | 1 | Host asks for one byte |
| tx_valid | output | 1 | Asserted the cycle after tx_req |
| tx_byte | output | 8 | Byte returned to host, valid with tx_valid |
| prog_strobe | input | 1 | Programming pulse stand-in |

## Verification
The bench reads the whole data field both erased and after programming. This separates correct address stepping and end-of-field handling from off-by-one errors at 00BFh and 0107h. It writes a full page and the whole status field in one auto-incrementing sequence and checks every CRC. That shows the difference between a CRC re-seeded with the new address and one merely continued. It also repeats programming of an already written byte, which distinguishes AND from overwrite. Stray strobes, unknown command bytes, bus resets in mid-read and out-of-field start addresses each check, through later reads, that nothing was stored and that no CRC leaks out.

// File: rtl/otp_pkg.sv
package otp_pkg;

    localparam logic [7:0] CMD_RD_DATA = 8'hF0;
    localparam logic [7:0] CMD_WR_DATA = 8'h0F;
    localparam logic [7:0] CMD_RD_STAT = 8'hAA;
    localparam logic [7:0] CMD_WR_STAT = 8'h55;

    // reflected form of x^16 + x^15 + x^2 + 1
    localparam logic [15:0] CRC_POLY_REFL = 16'hA001;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR_LO,
        ST_ADDR_HI,
        ST_HDR_CRC,
        ST_RD_DATA,
        ST_RD_CRC,
        ST_WR_DATA,
        ST_WR_CRC,
        ST_WAIT_PROG,
        ST_VERIFY,
        ST_DONE
    } eng_state_t;

    typedef enum logic [1:0] {
        CRC_HOLD,
        CRC_CLEAR,
        CRC_SHIFT,
        CRC_LOAD
    } crc_op_t;

    typedef struct packed {
        logic is_write;
        logic is_status;
    } cmd_kind_t;

    function automatic logic cmd_known(input logic [7:0] b);
        return (b == CMD_RD_DATA) || (b == CMD_WR_DATA) ||
               (b == CMD_RD_STAT) || (b == CMD_WR_STAT);
    endfunction

    function automatic cmd_kind_t cmd_decode(input logic [7:0] b);
        cmd_kind_t k;
        k.is_write  = (b == CMD_WR_DATA) || (b == CMD_WR_STAT);
        k.is_status = (b == CMD_RD_STAT) || (b == CMD_WR_STAT);
        return k;
    endfunction

    // one byte through the CRC, least significant bit first
    function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ b[i]) r = (r >> 1) ^ CRC_POLY_REFL;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/otp_crc16.sv
module otp_crc16
    import otp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  crc_op_t     op,
    input  logic [7:0]  din,
    output logic [15:0] crc_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= 16'h0000;
        end else begin
            unique case (op)
                CRC_CLEAR: crc_q <= 16'h0000;
                CRC_SHIFT: crc_q <= crc16_byte(crc_q, din);
                CRC_LOAD:  crc_q <= {8'h00, din};
                default:   crc_q <= crc_q;
            endcase
        end
    end

endmodule

// File: rtl/otp_store.sv
module otp_store #(
    parameter int DATA_BYTES = 192,
    parameter int STAT_BYTES = 8,
    parameter int STAT_WR    = 7,
    parameter int STAT_BASE  = 256
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sel_stat,
    input  logic [15:0] addr,
    input  logic        prog_en,
    input  logic [7:0]  prog_byte,
    output logic [7:0]  rd_byte
);

    localparam int TOTAL = DATA_BYTES + STAT_BYTES;
    localparam int IDXW  = $clog2(TOTAL);

    logic [7:0]      mem_q [TOTAL];
    logic [15:0]     stat_off;
    logic            in_data;
    logic            in_stat;
    logic            hit;
    logic            writable;
    logic [IDXW-1:0] idx;

    always_comb begin
        stat_off = addr - 16'(STAT_BASE);
        in_data  = !sel_stat && (addr < 16'(DATA_BYTES));
        in_stat  = sel_stat && (addr >= 16'(STAT_BASE)) && (stat_off < 16'(STAT_BYTES));
        hit      = in_data || in_stat;
        writable = in_data || (in_stat && (stat_off < 16'(STAT_WR)));
        if (in_stat) idx = IDXW'(stat_off) + IDXW'(DATA_BYTES);
        else         idx = addr[IDXW-1:0];
        rd_byte  = hit ? mem_q[idx] : 8'hFF;
    end

    for (genvar i = 0; i < TOTAL; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst)
                mem_q[i] <= 8'hFF;
            else if (prog_en && writable && (idx == IDXW'(i)))
                mem_q[i] <= mem_q[i] & prog_byte;
        end

        // a cell may only lose ones when programmed
        p_only_clear_r3: assert property (@(posedge clk) disable iff (rst)
            prog_en |=> ((mem_q[i] | $past(mem_q[i])) == $past(mem_q[i])));

        // without a programming request nothing moves
        p_hold_unless_prog_r9: assert property (@(posedge clk) disable iff (rst)
            !prog_en |=> $stable(mem_q[i]));
    end

endmodule

// File: rtl/otp_cmd_engine.sv
module otp_cmd_engine
    import otp_pkg::*;
#(
    parameter int DATA_BYTES = 192,
    parameter int STAT_BYTES = 8,
    parameter int STAT_WR    = 7,
    parameter int STAT_BASE  = 256
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_rst,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       tx_req,
    output logic       tx_valid,
    output logic [7:0] tx_byte,
    input  logic       prog_strobe
);

    localparam logic [15:0] DATA_END = 16'(DATA_BYTES - 1);
    localparam logic [15:0] STAT_LO  = 16'(STAT_BASE);
    localparam logic [15:0] STAT_END = 16'(STAT_BASE + STAT_BYTES - 1);

    eng_state_t  state_q, state_d;
    cmd_kind_t   kind_q, kind_d;
    logic [15:0] addr_q, addr_d;
    logic [15:0] addr_next;
    logic [15:0] hi_addr;
    logic [15:0] field_end;
    logic [7:0]  buf_q, buf_d;
    logic        half_q, half_d;
    logic [7:0]  crc_sel;
    logic [7:0]  tx_out;
    logic        prog_en;
    crc_op_t     crc_op;
    logic [7:0]  crc_din;
    logic [15:0] crc_q;
    logic [7:0]  rd_byte;

    function automatic logic start_ok(input logic st, input logic [15:0] a);
        if (st) return (a >= STAT_LO) && (a <= STAT_END);
        return a <= DATA_END;
    endfunction

    otp_crc16 crc_i (
        .clk   (clk),
        .rst   (rst),
        .op    (crc_op),
        .din   (crc_din),
        .crc_q (crc_q)
    );

    otp_store #(
        .DATA_BYTES (DATA_BYTES),
        .STAT_BYTES (STAT_BYTES),
        .STAT_WR    (STAT_WR),
        .STAT_BASE  (STAT_BASE)
    ) store_i (
        .clk       (clk),
        .rst       (rst),
        .sel_stat  (kind_q.is_status),
        .addr      (addr_q),
        .prog_en   (prog_en),
        .prog_byte (buf_q),
        .rd_byte   (rd_byte)
    );

    always_comb begin
        state_d   = state_q;
        kind_d    = kind_q;
        addr_d    = addr_q;
        buf_d     = buf_q;
        half_d    = half_q;
        crc_op    = CRC_HOLD;
        crc_din   = 8'h00;
        tx_out    = 8'hFF;
        prog_en   = 1'b0;
        addr_next = addr_q + 16'd1;
        hi_addr   = {rx_byte, addr_q[7:0]};
        field_end = kind_q.is_status ? STAT_END : DATA_END;
        crc_sel   = half_q ? crc_q[15:8] : crc_q[7:0];

        if (bus_rst) begin
            state_d = ST_IDLE;
            half_d  = 1'b0;
            crc_op  = CRC_CLEAR;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (rx_valid && cmd_known(rx_byte)) begin
                        kind_d  = cmd_decode(rx_byte);
                        crc_op  = CRC_SHIFT;
                        crc_din = rx_byte;
                        state_d = ST_ADDR_LO;
                    end
                end
                ST_ADDR_LO: begin
                    if (rx_valid) begin
                        addr_d[7:0] = rx_byte;
                        crc_op      = CRC_SHIFT;
                        crc_din     = rx_byte;
                        state_d     = ST_ADDR_HI;
                    end
                end
                ST_ADDR_HI: begin
                    if (rx_valid) begin
                        addr_d  = hi_addr;
                        crc_din = rx_byte;
                        if (kind_q.is_write) begin
                            crc_op  = CRC_SHIFT;
                            state_d = ST_WR_DATA;
                        end else if (kind_q.is_status) begin
                            crc_op  = CRC_SHIFT;
                            state_d = ST_HDR_CRC;
                        end else begin
                            crc_op  = CRC_CLEAR;
                            state_d = start_ok(1'b0, hi_addr) ? ST_RD_DATA : ST_DONE;
                        end
                    end
                end
                ST_HDR_CRC: begin
                    if (tx_req) begin
                        tx_out = crc_sel;
                        half_d = !half_q;
                        if (half_q) begin
                            crc_op  = CRC_CLEAR;
                            state_d = start_ok(1'b1, addr_q) ? ST_RD_DATA : ST_DONE;
                        end
                    end
                end
                ST_RD_DATA: begin
                    if (tx_req) begin
                        tx_out  = rd_byte;
                        crc_op  = CRC_SHIFT;
                        crc_din = rd_byte;
                        if (addr_q == field_end) state_d = ST_RD_CRC;
                        else                     addr_d  = addr_next;
                    end
                end
                ST_RD_CRC: begin
                    if (tx_req) begin
                        tx_out = crc_sel;
                        half_d = !half_q;
                        if (half_q) state_d = ST_DONE;
                    end
                end
                ST_WR_DATA: begin
                    if (rx_valid) begin
                        buf_d   = rx_byte;
                        crc_op  = CRC_SHIFT;
                        crc_din = rx_byte;
                        state_d = ST_WR_CRC;
                    end
                end
                ST_WR_CRC: begin
                    if (tx_req) begin
                        tx_out = crc_sel;
                        half_d = !half_q;
                        if (half_q) state_d = ST_WAIT_PROG;
                    end
                end
                ST_WAIT_PROG: begin
                    if (prog_strobe) begin
                        prog_en = 1'b1;
                        state_d = ST_VERIFY;
                    end
                end
                ST_VERIFY: begin
                    if (tx_req) begin
                        tx_out  = rd_byte;
                        addr_d  = addr_next;
                        crc_op  = CRC_LOAD;
                        crc_din = addr_next[7:0];
                        state_d = ST_WR_DATA;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            kind_q   <= '0;
            addr_q   <= 16'h0000;
            buf_q    <= 8'hFF;
            half_q   <= 1'b0;
            tx_valid <= 1'b0;
            tx_byte  <= 8'hFF;
        end else begin
            state_q  <= state_d;
            kind_q   <= kind_d;
            addr_q   <= addr_d;
            buf_q    <= buf_d;
            half_q   <= half_d;
            tx_valid <= tx_req;
            if (tx_req) tx_byte <= tx_out;
        end
    end

    // once the sequence is spent, only filler ones come out
    p_done_ones_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DONE && tx_req && !bus_rst) |=> (tx_byte == 8'hFF));

    // a bus reset always lands in the command wait
    p_bus_reset_idle_r11: assert property (@(posedge clk) disable iff (rst)
        bus_rst |=> (state_q == ST_IDLE));

    // verify read moves the address by exactly one
    p_addr_step_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_VERIFY && tx_req && !bus_rst) |=> (addr_q == $past(addr_q) + 16'd1));

    // the CRC register is re-seeded from the new address low byte
    p_reseed_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_VERIFY && tx_req && !bus_rst) |=> (crc_q == {8'h00, addr_q[7:0]}));

    // programming only ever happens from the wait state
    p_prog_from_wait_r9: assert property (@(posedge clk) disable iff (rst)
        (prog_strobe && state_q != ST_WAIT_PROG) |=> (state_q != ST_VERIFY || $past(state_q) == ST_VERIFY));

endmodule

// File: tb/otp_cmd_engine_tb.sv
`timescale 1ns/1ps
module otp_cmd_engine_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_rst = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       tx_req = 1'b0;
    logic       tx_valid;
    logic [7:0] tx_byte;
    logic       prog_strobe = 1'b0;

    int n_chk = 0;
    int n_err = 0;
    bit reported = 1'b0;

    logic [7:0] mem_m [200];

    always #4 clk = ~clk;

    otp_cmd_engine dut_i (
        .clk         (clk),
        .rst         (rst),
        .bus_rst     (bus_rst),
        .rx_valid    (rx_valid),
        .rx_byte     (rx_byte),
        .tx_req      (tx_req),
        .tx_valid    (tx_valid),
        .tx_byte     (tx_byte),
        .prog_strobe (prog_strobe)
    );

    function automatic logic [15:0] crc_b(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r = c;
        for (int k = 0; k < 8; k++) begin
            logic fb = r[0] ^ b[k];
            r = {1'b0, r[15:1]};
            if (fb) r = r ^ 16'hA001;
        end
        return r;
    endfunction

    function automatic int midx(input logic st, input logic [15:0] a);
        if (!st && a <= 16'h00BF) return int'(a);
        if (st && a >= 16'h0100 && a <= 16'h0107) return 192 + int'(a - 16'h0100);
        return -1;
    endfunction

    function automatic bit can_write(input logic st, input logic [15:0] a);
        if (st) return a >= 16'h0100 && a <= 16'h0106;
        return a <= 16'h00BF;
    endfunction

    function automatic logic [7:0] model_rd(input logic st, input logic [15:0] a);
        int i = midx(st, a);
        if (i < 0) return 8'hFF;
        return mem_m[i];
    endfunction

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        end
    endtask

    task automatic chk8(input logic [7:0] act, input logic [7:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic chk16(input logic [15:0] act, input logic [15:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic get(output logic [7:0] b);
        @(negedge clk);
        tx_req = 1'b1;
        @(negedge clk);
        tx_req = 1'b0;
        b = tx_byte;
    endtask

    task automatic get16(output logic [15:0] w);
        logic [7:0] lo, hi;
        get(lo);
        get(hi);
        w = {hi, lo};
    endtask

    task automatic strobe();
        @(negedge clk);
        prog_strobe = 1'b1;
        @(negedge clk);
        prog_strobe = 1'b0;
    endtask

    task automatic bus_reset();
        @(negedge clk);
        bus_rst = 1'b1;
        @(negedge clk);
        bus_rst = 1'b0;
    endtask

    task automatic cmd_hdr(input logic [7:0] c, input logic [15:0] a, output logic [15:0] crc);
        put(c);
        put(a[7:0]);
        put(a[15:8]);
        crc = crc_b(crc_b(crc_b(16'h0000, c), a[7:0]), a[15:8]);
    endtask

    // R7: stream data field from start to end, CRC over data, then ones
    task automatic read_data(input logic [15:0] start);
        logic [15:0] hc, c, w;
        logic [7:0]  b;
        cmd_hdr(8'hF0, start, hc);
        c = 16'h0000;
        for (int a = int'(start); a <= 16'h00BF; a++) begin
            get(b);
            chk8(b, model_rd(1'b0, 16'(a)), $sformatf("R7 data byte at %h", a));
            c = crc_b(c, model_rd(1'b0, 16'(a)));
        end
        get16(w);
        chk16(w, c, "R7 closing CRC of data field");
        get(b);
        chk8(b, 8'hFF, "R7 filler after CRC");
        bus_reset();
    endtask

    // R8: header CRC, status bytes, CRC, ones
    task automatic read_stat(input logic [15:0] start);
        logic [15:0] hc, c, w;
        logic [7:0]  b;
        cmd_hdr(8'hAA, start, hc);
        get16(w);
        chk16(w, hc, "R8 header CRC of command and address");
        c = 16'h0000;
        for (int a = int'(start); a <= 16'h0107; a++) begin
            get(b);
            chk8(b, model_rd(1'b1, 16'(a)), $sformatf("R8 status byte at %h", a));
            c = crc_b(c, model_rd(1'b1, 16'(a)));
        end
        get16(w);
        chk16(w, c, "R8 closing CRC of status field");
        get(b);
        chk8(b, 8'hFF, "R8 filler after CRC");
        bus_reset();
    endtask

    // one data byte of a write: CRC (R4/R6), strobe, verify (R5/R3/R10)
    task automatic wr_step(input logic st, input logic [15:0] a, input logic [7:0] d,
                           input logic [15:0] seed, input string tag);
        logic [15:0] w;
        logic [7:0]  b;
        int          i;
        put(d);
        get16(w);
        chk16(w, crc_b(seed, d), $sformatf("%s CRC at %h", tag, a));
        strobe();
        i = midx(st, a);
        if (can_write(st, a) && i >= 0) mem_m[i] = mem_m[i] & d;
        get(b);
        chk8(b, model_rd(st, a), $sformatf("R5 verify byte at %h", a));
    endtask

    // write n bytes from start with data computed per index
    task automatic wr_run(input logic st, input logic [15:0] start, input int n, input logic [7:0] base);
        logic [15:0] seed;
        logic [15:0] a;
        cmd_hdr(st ? 8'h55 : 8'h0F, start, seed);
        a = start;
        for (int k = 0; k < n; k++) begin
            wr_step(st, a, base ^ 8'(k * 37), seed, (k == 0) ? "R4 first write" : "R6 reseeded write");
            a    = a + 16'd1;
            seed = {8'h00, a[7:0]};
        end
        bus_reset();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        report();
        $finish;
    end

    initial begin
        logic [15:0] w, hc;
        logic [7:0]  b;
        for (int i = 0; i < 200; i++) mem_m[i] = 8'hFF;

        repeat (5) @(negedge clk);
        chk8({7'd0, tx_valid}, 8'h00, "R2 tx_valid in reset");
        chk8(tx_byte, 8'hFF, "R2 tx_byte in reset");
        rst = 1'b0;

        // erased contents of both fields
        read_data(16'h0000);
        read_stat(16'h0100);

        // R9: strobe while idle, then a read shows nothing moved
        strobe();
        // single write, then AND over an existing byte
        wr_run(1'b0, 16'h0005, 2, 8'hA5);
        wr_run(1'b0, 16'h0005, 1, 8'h5A);
        read_data(16'h0000);

        // a full page in one auto-incrementing sequence
        wr_run(1'b0, 16'h0020, 32, 8'h6C);

        // R10: crossing the data field end
        wr_run(1'b0, 16'h00BF, 2, 8'h81);

        // R9: strobe too early (CRC phase) changes nothing
        cmd_hdr(8'h0F, 16'h0010, hc);
        put(8'h00);
        strobe();
        get16(w);
        chk16(w, crc_b(hc, 8'h00), "R9 CRC after stray strobe");
        bus_reset();
        read_data(16'h0000);

        // status field: all eight, last one not writable
        wr_run(1'b1, 16'h0100, 8, 8'h0E);
        read_stat(16'h0103);
        // R10: write status outside its range
        wr_run(1'b1, 16'h0050, 1, 8'h00);
        read_stat(16'h0100);

        // R11: read cut short by bus reset gets no CRC
        cmd_hdr(8'hF0, 16'h0000, hc);
        for (int k = 0; k < 3; k++) begin
            get(b);
            chk8(b, mem_m[k], "R11 partial read byte");
        end
        bus_reset();
        get(b);
        chk8(b, 8'hFF, "R11 request after bus reset");
        get(b);
        chk8(b, 8'hFF, "R11 second request after bus reset");

        // R1: unknown command byte dropped, next byte starts sequence
        put(8'h33);
        cmd_hdr(8'hF0, 16'h00BF, hc);
        get(b);
        chk8(b, mem_m[191], "R1 read after dropped command byte");
        get16(w);
        chk16(w, crc_b(16'h0000, mem_m[191]), "R1 CRC after dropped command byte");
        bus_reset();

        // R12: start outside the field
        cmd_hdr(8'hF0, 16'h0100, hc);
        get(b);
        chk8(b, 8'hFF, "R12 data read past field");
        get(b);
        chk8(b, 8'hFF, "R12 data read past field, no CRC");
        bus_reset();
        cmd_hdr(8'hAA, 16'h0050, hc);
        get16(w);
        chk16(w, hc, "R12 status header CRC still sent");
        get(b);
        chk8(b, 8'hFF, "R12 status read outside field");
        get(b);
        chk8(b, 8'hFF, "R12 status read outside field, no CRC");
        bus_reset();

        report();
        $finish;
    end

endmodule